// File: doc/BRIEF.md
# Label-Filtered Receive Word Buffer

This block sits behind a serial receive decoder. The decoder hands over each completed 32-bit word together with a one-cycle completion strobe. The block then decides whether to keep the word. Two filters can be switched on independently. The first compares the word's 8-bit label against a 16-entry label memory. The second compares the two source/destination bits against a programmed pair. A word that fails an enabled filter leaves no trace. Kept words enter a 32-word queue, and a host drains the queue as two 16-bit halves.

The host sees three flags: data ready, half full and full. When the queue is full, a newly kept word replaces the newest stored entry. A control input selects a label access mode, in which the same host strobes load or read back the label memory. A format input selects one of two layouts of the word's bits on the 16-bit bus.

Top module: `arinc_rx_filter_fifo`

## Requirements
- R1: With `label_chk_en`=1, a word is kept only if its bits [7:0] (received bits 1–8) equal one of the 16 stored labels. The value 8'h00 matches like any other value. A dropped word changes no flag.
- R2: With `sdi_chk_en`=1, a word is kept only if `word_in[9:8]` equals `sdi_ref[1:0]` (bit 8 compared to `sdi_ref[0]`). With both checks off, every strobed word is kept.
- R3: The queue holds 32 words and `full` is 1 at 32. If a word is kept while the queue is full and no word is leaving, it replaces the newest entry, and the 31 older entries are left unchanged.
- R4: `half_full` is 1 exactly while 16 or more words are stored.
- R5: A word leaves the queue once both halves have been read with `host_rd`, in either order. Repeating a read of the same half does not remove it. `data_ready` stays 1 until the queue is empty.
- R6: With `packed_fmt`=0, `host_sel`=0 returns `word[15:0]` and `host_sel`=1 returns `word[31:16]`.
- R7: With `packed_fmt`=1, `host_sel`=1 returns `word[28:13]`. `host_sel`=0 returns these bits, from bus bit 15 down to bus bit 0: `word[12:8]`, `word[30]`, `word[29]`, `word[31]`, then `word[0]` through `word[7]`. Label matching always uses `word[7:0]`.
- R8: Each rise of `label_mode` resets the label index to 0. The next 16 `host_wr` pulses store `host_wdata` into entries 0–15 in turn, and any further writes are ignored. While `label_mode`=1, incoming words are not kept.
- R9: While `label_mode`=1, each `host_rd` returns the next stored label on `host_rdata[7:0]`, with zeros in the upper bits. A read past the 16th entry returns zero. Label reads leave the queue unchanged.
- R10: Reset (`rst_n`=0) empties the queue and clears all three flags. The label memory is retained.
- R11: When a word is kept in the same cycle that a read removes a word from a full queue, the removal happens first and the new word is appended. `full` stays 1, and the new word comes out last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of queue and flags |
| word_stb | input | 1 | Completed-word strobe from the decoder |
| word_in | input | 32 | Received word, bit 0 = first received bit |
| label_mode | input | 1 | Label memory access mode |
| label_chk_en | input | 1 | Enable label filter |
| sdi_chk_en | input | 1 | Enable source/destination filter |
| sdi_ref | input | 2 | Expected value of word bits 9:8 |
| packed_fmt | input | 1 | Select the alternate bus layout |
| host_wr | input | 1 | Label write strobe (label mode only) |
| host_wdata | input | 8 | Label write data |
| host_rd | input | 1 | Host read strobe |
| host_sel | input | 1 | Half select: 0 lower, 1 upper |
| host_rdata | output | 16 | Read data |
| data_ready | output | 1 | Queue not empty |
| half_full | output | 1 | 16 or more words stored |
| full | output | 1 | 32 words stored |

## Verification
The queue's write path and its removal path can act in the same cycle. The case with real consequences is a full queue, where an incoming word could either overwrite the newest entry or be appended behind a departing one. The bench fills the queue to 32 and reads the first half of the oldest word. It then strobes a new word in the same cycle as the second-half read. It judges the result by `full` staying high and by the drained order: the 31 survivors come out in sequence and the new word comes out last, with no entry overwritten. A separate full-queue case with no read pending confirms that the newest entry is replaced instead.

// File: rtl/arinc_rx_filter_fifo.sv
module arinc_rx_filter_fifo #(
  parameter int DEPTH    = 32,
  parameter int LBL_N    = 16,
  parameter int HF_LEVEL = DEPTH / 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        word_stb,
  input  logic [31:0] word_in,
  input  logic        label_mode,
  input  logic        label_chk_en,
  input  logic        sdi_chk_en,
  input  logic [1:0]  sdi_ref,
  input  logic        packed_fmt,
  input  logic        host_wr,
  input  logic [7:0]  host_wdata,
  input  logic        host_rd,
  input  logic        host_sel,
  output logic [15:0] host_rdata,
  output logic        data_ready,
  output logic        half_full,
  output logic        full
);
  localparam int AW  = $clog2(DEPTH);
  localparam int CW  = $clog2(DEPTH + 1);
  localparam int LIW = $clog2(LBL_N);
  localparam int LW  = $clog2(LBL_N + 1);

  logic [7:0]  lbl_mem [LBL_N];
  logic [LW-1:0] lbl_idx;
  logic [LBL_N-1:0] lbl_hits;
  logic        lbl_hit, lbl_idx_ok;

  logic [31:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic        got_lo, got_hi;
  logic        accept, rd_fifo, pop, push_new, ovw, is_full;
  logic [31:0] head;
  logic [15:0] lo_plain, hi_plain, lo_pack, hi_pack;

  for (genvar i = 0; i < LBL_N; i++) begin : g_match
    assign lbl_hits[i] = (lbl_mem[i] == word_in[7:0]);
  end
  assign lbl_hit    = |lbl_hits;
  assign lbl_idx_ok = lbl_idx < LW'(LBL_N);

  assign accept = word_stb && !label_mode
               && (!label_chk_en || lbl_hit)
               && (!sdi_chk_en || (word_in[9:8] == sdi_ref));

  assign is_full  = (cnt == CW'(DEPTH));
  assign rd_fifo  = host_rd && !label_mode && (cnt != '0);
  assign pop      = rd_fifo && (host_sel ? got_lo : got_hi);
  assign push_new = accept && (!is_full || pop);
  assign ovw      = accept && is_full && !pop;

  always_ff @(posedge clk) begin
    if (label_mode && host_wr && lbl_idx_ok)
      lbl_mem[lbl_idx[LIW-1:0]] <= host_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      lbl_idx <= '0;
    else if (!label_mode)
      lbl_idx <= '0;
    else if ((host_wr || host_rd) && lbl_idx_ok)
      lbl_idx <= lbl_idx + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (push_new)
      mem[wp] <= word_in;
    else if (ovw)
      mem[wp - 1'b1] <= word_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      cnt <= '0;
      got_lo <= 1'b0;
      got_hi <= 1'b0;
    end else begin
      if (pop) begin
        rp <= rp + 1'b1;
        got_lo <= 1'b0;
        got_hi <= 1'b0;
      end else if (rd_fifo) begin
        if (host_sel) got_hi <= 1'b1;
        else          got_lo <= 1'b1;
      end
      if (push_new) wp <= wp + 1'b1;
      cnt <= cnt + CW'(push_new) - CW'(pop);
    end
  end

  assign head     = mem[rp];
  assign lo_plain = head[15:0];
  assign hi_plain = head[31:16];
  assign lo_pack  = {head[12:8], head[30], head[29], head[31],
                     head[0], head[1], head[2], head[3],
                     head[4], head[5], head[6], head[7]};
  assign hi_pack  = head[28:13];

  always_comb begin
    if (label_mode)
      host_rdata = {8'h00, lbl_idx_ok ? lbl_mem[lbl_idx[LIW-1:0]] : 8'h00};
    else if (cnt == '0)
      host_rdata = '0;
    else if (packed_fmt)
      host_rdata = host_sel ? hi_pack : lo_pack;
    else
      host_rdata = host_sel ? hi_plain : lo_plain;
  end

  assign data_ready = (cnt != '0);
  assign half_full  = (cnt >= CW'(HF_LEVEL));
  assign full       = is_full;

  AST_DROP_NO_LABEL: assert property (@(posedge clk) disable iff (!rst_n)
    (word_stb && label_chk_en && !lbl_hit && !host_rd) |=> $stable(cnt)); // R1
  AST_DROP_SDI: assert property (@(posedge clk) disable iff (!rst_n)
    (word_stb && sdi_chk_en && (word_in[9:8] != sdi_ref) && !host_rd) |=> $stable(cnt)); // R2
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !host_rd) |=> full); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH)); // R3
  AST_NO_LOSS_WITHOUT_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |=> cnt >= $past(cnt)); // R5
  AST_LABEL_MODE_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    label_mode |=> cnt <= $past(cnt)); // R8
  AST_FULL_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (full && accept && pop) |=> full); // R11
endmodule

// File: tb/arinc_rx_filter_fifo_test.sv
module arinc_rx_filter_fifo_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic word_stb = 0, label_mode = 0, label_chk_en = 0, sdi_chk_en = 0, packed_fmt = 0;
  logic [31:0] word_in = '0;
  logic [1:0] sdi_ref = '0;
  logic host_wr = 0, host_rd = 0, host_sel = 0;
  logic [7:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic data_ready, half_full, full;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  arinc_rx_filter_fifo uut (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] lbl_val(input int i);
    return (i == 0) ? 8'h00 : 8'(8'h30 + 3 * i);
  endfunction

  function automatic logic [15:0] pack_half(input logic [31:0] w, input bit sel);
    logic [15:0] r;
    for (int b = 0; b < 16; b++) begin
      int arinc;
      if (sel) arinc = 14 + b;
      else if (b < 8) arinc = 8 - b;
      else if (b == 8) arinc = 32;
      else if (b == 9) arinc = 30;
      else if (b == 10) arinc = 31;
      else arinc = b - 2;
      r[b] = w[arinc - 1];
    end
    return r;
  endfunction

  task automatic push(input logic [31:0] w);
    word_stb = 1; word_in = w;
    @(negedge clk);
    word_stb = 0;
  endtask

  task automatic read_word(input bit hi_first, output logic [15:0] lo, output logic [15:0] hi);
    host_rd = 1; host_sel = hi_first; #1;
    if (hi_first) hi = host_rdata; else lo = host_rdata;
    @(negedge clk);
    host_sel = ~hi_first; #1;
    if (hi_first) lo = host_rdata; else hi = host_rdata;
    @(negedge clk);
    host_rd = 0;
  endtask

  task automatic t_reset;
    check(!data_ready && !half_full && !full, "R10 reset flags", {data_ready, half_full, full}, 0);
  endtask

  task automatic t_labels;
    label_mode = 1;
    @(negedge clk);
    for (int i = 0; i < 17; i++) begin
      host_wr = 1; host_wdata = (i == 16) ? 8'hAA : lbl_val(i);
      @(negedge clk);
    end
    host_wr = 0;
    push(32'h0000_0033);
    label_mode = 0;
    @(negedge clk);
    check(!data_ready, "R8 reception suspended", data_ready, 0);
    label_mode = 1;
    @(negedge clk);
    for (int i = 0; i < 17; i++) begin
      host_rd = 1; #1;
      check(host_rdata == ((i == 16) ? 16'h0 : {8'h0, lbl_val(i)}), "R9 label readback",
            host_rdata, (i == 16) ? 16'h0 : {8'h0, lbl_val(i)});
      @(negedge clk);
    end
    host_rd = 0;
    label_mode = 0;
    @(negedge clk);
    check(!data_ready, "R9 queue untouched", data_ready, 0);
  endtask

  task automatic t_label_filter;
    logic [15:0] lo, hi;
    label_chk_en = 1;
    push(32'h1234_5655);
    check(!data_ready, "R1 unmatched dropped", data_ready, 0);
    push(32'hABCD_0100);
    check(data_ready, "R1 label 00 kept", data_ready, 1);
    push(32'h0F0F_0236);
    read_word(0, lo, hi);
    check({hi, lo} == 32'hABCD_0100, "R1 first kept word", {hi, lo}, 32'hABCD_0100);
    read_word(0, lo, hi);
    check({hi, lo} == 32'h0F0F_0236, "R1 second kept word", {hi, lo}, 32'h0F0F_0236);
    check(!data_ready, "R1 empty after", data_ready, 0);
    label_chk_en = 0;
  endtask

  task automatic t_sdi;
    logic [15:0] lo, hi;
    sdi_chk_en = 1; sdi_ref = 2'b10;
    push(32'h0000_0177);
    check(!data_ready, "R2 mismatched sdi dropped", data_ready, 0);
    push(32'h5555_0277);
    read_word(0, lo, hi);
    check({hi, lo} == 32'h5555_0277, "R2 matched sdi kept", {hi, lo}, 32'h5555_0277);
    sdi_chk_en = 0;
    push(32'h0000_0177);
    check(data_ready, "R2 checks off keeps all", data_ready, 1);
    read_word(0, lo, hi);
  endtask

  task automatic t_format;
    logic [15:0] lo, hi;
    logic [31:0] w = 32'hB6D3_9A5C;
    push(w);
    read_word(1, lo, hi);
    check(lo == w[15:0] && hi == w[31:16], "R6 plain mapping", {hi, lo}, w);
    packed_fmt = 1;
    push(w);
    read_word(0, lo, hi);
    check(lo == pack_half(w, 0), "R7 packed lower half", lo, pack_half(w, 0));
    check(hi == pack_half(w, 1), "R7 packed upper half", hi, pack_half(w, 1));
    packed_fmt = 0;
  endtask

  task automatic t_ready;
    push(32'hCAFE_0001);
    host_rd = 1; host_sel = 0;
    @(negedge clk); @(negedge clk);
    host_rd = 0;
    check(data_ready, "R5 same half twice keeps word", data_ready, 1);
    host_rd = 1; host_sel = 1;
    @(negedge clk);
    host_rd = 0;
    check(!data_ready, "R5 both halves empties", data_ready, 0);
  endtask

  function automatic logic [31:0] fw(input int i);
    return 32'h1000_0000 + i * 32'h0001_0101;
  endfunction

  task automatic t_fill;
    logic [15:0] lo, hi;
    for (int i = 0; i < 15; i++) push(fw(i));
    check(!half_full, "R4 15 words not half", half_full, 0);
    push(fw(15));
    check(half_full && !full, "R4 16 words half", {half_full, full}, 2'b10);
    for (int i = 16; i < 32; i++) push(fw(i));
    check(full, "R3 32 words full", full, 1);
    push(32'hDEAD_BEEF);
    check(full, "R3 still full after overwrite", full, 1);
    for (int i = 0; i < 32; i++) begin
      logic [31:0] e = (i == 31) ? 32'hDEAD_BEEF : fw(i);
      read_word(0, lo, hi);
      if (i == 0 || i >= 30) check({hi, lo} == e, "R3 drain order", {hi, lo}, e);
      if (i == 16) check(!half_full, "R4 back below 16", half_full, 0);
    end
    check(!data_ready, "R3 empty after drain", data_ready, 0);
  endtask

  task automatic t_collide;
    logic [15:0] lo, hi;
    for (int i = 0; i < 32; i++) push(fw(i + 40));
    host_rd = 1; host_sel = 0;
    @(negedge clk);
    host_sel = 1; word_stb = 1; word_in = 32'h7777_8888;
    @(negedge clk);
    host_rd = 0; word_stb = 0;
    check(full, "R11 full after read and write", full, 1);
    for (int i = 1; i <= 32; i++) begin
      logic [31:0] e = (i == 32) ? 32'h7777_8888 : fw(i + 40);
      read_word(0, lo, hi);
      if (i == 1 || i >= 31) check({hi, lo} == e, "R11 order", {hi, lo}, e);
    end
  endtask

  task automatic t_reset_keep;
    push(32'h1111_2222);
    push(32'h3333_4444);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!data_ready && !half_full && !full, "R10 reset clears", {data_ready, half_full, full}, 0);
    label_chk_en = 1;
    push(32'h9999_0039);
    check(data_ready, "R10 labels kept across reset", data_ready, 1);
    label_chk_en = 0;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_labels;
    t_label_filter;
    t_sdi;
    t_format;
    t_ready;
    t_fill;
    t_collide;
    t_reset_keep;
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule